// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block sequences power for an add-in card that can be plugged into a host while the host is running. It watches two card-seated contacts, four rail-good comparator flags (host 5 V, host 3.3 V, card 5 V, card 3.3 V) and a host reset request. It drives the gate enables of the two rail switches, a bus driver enable, two status flags and a card reset in both polarities. Every status input passes through a two-flop synchronizer and a run-length glitch filter before the sequencer acts on it.

Power-up runs in order. The block waits until the card is fully seated and the host rails are good. It then holds off for a fixed settling delay and switches both rails on. Once the card rails report good, it keeps the card in reset for a power-on reset interval, then releases reset and raises the status flags. If a rail falls out of range, or either seated contact opens, while the card is powered, the card loses power and goes into reset. A host reset request is stretched to at least one power-on reset interval. Delays are parameters counted in clock cycles: `T_HSE` (settling), `T_PURST` (reset interval) and `FILT_N` (filter run length).

Top module: `hotswap_seq`

## Requirements
- R1: `gate5_en`, `gate3_en` and `drv_en` stay low unless both `seated_a` and `seated_b` are 1 and both `host5_ok` and `host3_ok` are 1 (after filtering).
- R2: When both seated inputs and both host rail flags go to 1 together from idle, `gate5_en`, `gate3_en` and `drv_en` rise together exactly 3 + FILT_N + T_HSE clock cycles later.
- R3: With the rails enabled, when `card5_ok` and `card3_ok` both go to 1, `card_rst` falls and `card_pwr_ok` and `sig_ok` rise together exactly 3 + FILT_N + T_PURST cycles later. Until then `card_rst` stays 1.
- R4: If any of `host5_ok`, `host3_ok`, `card5_ok` or `card3_ok` goes to 0 while the card is powered, the gate enables, `drv_en`, `card_pwr_ok` and `sig_ok` drop and `card_rst` is 1 exactly 3 + FILT_N cycles later.
- R5: Opening either seated input while the card is powered has the same effect, with the same latency, as a rail fault.
- R6: A host reset request held for L cycles with L < T_PURST gives a `card_rst` pulse of exactly T_PURST cycles.
- R7: A host reset request held for L cycles with L >= T_PURST gives a `card_rst` pulse of exactly L cycles.
- R8: `card_rst_n` is always the complement of `card_rst`.
- R9: A status input that changes for fewer than FILT_N consecutive cycles has no effect. A change lasting FILT_N or more cycles is acted on.
- R10: During and right after reset, all enables and status flags are 0, `card_rst` is 1 and `card_rst_n` is 0.
- R11: A host reset request does not switch off the rails or `drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seated_a | input | 1 | First card-seated contact, 1 = seated |
| seated_b | input | 1 | Second card-seated contact, 1 = seated |
| host5_ok | input | 1 | Host 5 V above trip level |
| host3_ok | input | 1 | Host 3.3 V above trip level |
| card5_ok | input | 1 | Card 5 V above trip level |
| card3_ok | input | 1 | Card 3.3 V above trip level |
| host_rst_req | input | 1 | Host reset request, active high |
| gate5_en | output | 1 | 5 V switch gate enable |
| gate3_en | output | 1 | 3.3 V switch gate enable |
| drv_en | output | 1 | Bus driver enable |
| card_pwr_ok | output | 1 | Card rails valid and reset interval done |
| sig_ok | output | 1 | Card signals valid |
| card_rst | output | 1 | Card reset, active high |
| card_rst_n | output | 1 | Card reset, active low |

## Verification
Power-up is tried with only one contact seated and with one host rail missing, which separates the seat check from the rail check. The full bring-up then measures both sequencing delays to the exact cycle. Faults are injected one at a time: each of the four rail flags and each seated contact is dropped while running, so that every input is shown to lead to power-down. Host reset pulses are swept from 1 to T_PURST+3 cycles, which separates stretching from pass-through exactly at the boundary. Glitch lengths are swept from 1 to FILT_N cycles, which shows where the filter's threshold lies.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_RAMP = 3'd2,
    ST_HOLD = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/hs_sync_filt.sv
module hs_sync_filt #(
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = (FILT_N < 2) ? 1 : $clog2(FILT_N + 1);

  logic          s1_q, s2_q, q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    q_d   = q_q;
    cnt_d = '0;
    if (s2_q != q_q) begin
      if (cnt_q == CW'(FILT_N - 1)) begin
        q_d = s2_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= d;
      s2_q  <= s1_q;
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign q = q_q;

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_q) |-> ($past(s2_q) == q_q));
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (en && (cnt_q != limit))  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign hit = en && (cnt_q == limit);
endmodule

// File: rtl/hs_rst_stretch.sv
module hs_rst_stretch #(
  parameter int T_PURST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);
  localparam int SW = $clog2(T_PURST + 1);

  logic          req_d_q;
  logic [SW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    hcnt_d = hcnt_q;
    if (req && !req_d_q)       hcnt_d = SW'(T_PURST - 1);
    else if (hcnt_q != '0)     hcnt_d = hcnt_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      hcnt_q  <= '0;
    end else begin
      req_d_q <= req;
      hcnt_q  <= hcnt_d;
    end
  end

  assign active = req || (hcnt_q != '0);

  // R6
  stretch_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(hcnt_q) <= SW'(1)) && !$past(req && !req_d_q));
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int T_HSE   = 5,
  parameter int T_PURST = 8,
  parameter int FILT_N  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seated_a,
  input  logic seated_b,
  input  logic host5_ok,
  input  logic host3_ok,
  input  logic card5_ok,
  input  logic card3_ok,
  input  logic host_rst_req,
  output logic gate5_en,
  output logic gate3_en,
  output logic drv_en,
  output logic card_pwr_ok,
  output logic sig_ok,
  output logic card_rst,
  output logic card_rst_n
);
  import hs_pkg::*;

  localparam int NIN  = 6;
  localparam int TMAX = (T_HSE > T_PURST) ? T_HSE : T_PURST;
  localparam int TW   = $clog2(TMAX + 1);

  logic [NIN-1:0] raw_in, flt;
  logic           req_s;

  assign raw_in = {card3_ok, card5_ok, host3_ok, host5_ok, seated_b, seated_a};

  genvar gi;
  generate
    for (gi = 0; gi < NIN; gi++) begin : g_filt
      hs_sync_filt #(.FILT_N(FILT_N)) u_filt (
        .clk(clk), .rst_n(rst_n), .d(raw_in[gi]), .q(flt[gi]));
    end
  endgenerate

  hs_sync_filt #(.FILT_N(1)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(host_rst_req), .q(req_s));

  logic ready, card_ok;
  assign ready   = &flt[3:0];
  assign card_ok = &flt[5:4];

  seq_state_t state_q, state_d;
  logic [TW-1:0] tmr_cnt, tmr_lim;
  logic          tmr_hit, tmr_en, tmr_clr;

  assign tmr_en  = (state_q == ST_ARM) || (state_q == ST_HOLD);
  assign tmr_lim = (state_q == ST_ARM) ? TW'(T_HSE - 1) : TW'(T_PURST - 1);
  assign tmr_clr = (state_d != state_q);

  hs_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
    .limit(tmr_lim), .cnt(tmr_cnt), .hit(tmr_hit));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (ready) state_d = ST_ARM;
      ST_ARM: begin
        if (!ready)       state_d = ST_IDLE;
        else if (tmr_hit) state_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (!ready)       state_d = ST_IDLE;
        else if (card_ok) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!ready || !card_ok) state_d = ST_IDLE;
        else if (tmr_hit)       state_d = ST_RUN;
      end
      ST_RUN: if (!ready || !card_ok) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  logic hr_active, powered, running;

  hs_rst_stretch #(.T_PURST(T_PURST)) u_hrst (
    .clk(clk), .rst_n(rst_n), .req(req_s), .active(hr_active));

  assign powered     = (state_q == ST_RAMP) || (state_q == ST_HOLD) || (state_q == ST_RUN);
  assign running     = (state_q == ST_RUN);
  assign gate5_en    = powered;
  assign gate3_en    = powered;
  assign drv_en      = powered;
  assign card_pwr_ok = running;
  assign sig_ok      = running;
  assign card_rst    = !running || hr_active;
  assign card_rst_n  = !card_rst;

  // R1
  gate_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate5_en |-> $past(ready));

  // R2
  hse_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate5_en) |-> ($past(tmr_cnt) == TW'(T_HSE - 1)));

  // R3
  purst_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pwr_ok) |-> ($past(tmr_cnt) == TW'(T_PURST - 1)) && $past(card_ok));

  // R4
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && !ready) |=> (!gate5_en && card_rst));
endmodule

// File: tb/sim_hotswap_seq.sv
module sim_hotswap_seq;
  localparam int T_HSE   = 5;
  localparam int T_PURST = 8;
  localparam int FILT_N  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seated_a = 0, seated_b = 0, host5_ok = 0, host3_ok = 0;
  logic card5_ok = 0, card3_ok = 0, host_rst_req = 0;
  logic gate5_en, gate3_en, drv_en, card_pwr_ok, sig_ok, card_rst, card_rst_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hotswap_seq #(.T_HSE(T_HSE), .T_PURST(T_PURST), .FILT_N(FILT_N)) u0 (
    .clk(clk), .rst_n(rst_n), .seated_a(seated_a), .seated_b(seated_b),
    .host5_ok(host5_ok), .host3_ok(host3_ok), .card5_ok(card5_ok),
    .card3_ok(card3_ok), .host_rst_req(host_rst_req),
    .gate5_en(gate5_en), .gate3_en(gate3_en), .drv_en(drv_en),
    .card_pwr_ok(card_pwr_ok), .sig_ok(sig_ok),
    .card_rst(card_rst), .card_rst_n(card_rst_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges until the gate enable reaches the given level
  task automatic wait_gate(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (gate5_en !== lvl && n < 200);
  endtask

  task automatic bring_up();
    int n;
    seated_a = 1; seated_b = 1; host5_ok = 1; host3_ok = 1;
    card5_ok = 1; card3_ok = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (card_pwr_ok !== 1'b1 && n < 200);
    chk(card_pwr_ok === 1'b1, "R3", card_pwr_ok, 1);
  endtask

  task automatic fault_test(input int which, input string req);
    int n;
    bring_up();
    cyc(3);
    case (which)
      0: host5_ok = 0;
      1: host3_ok = 0;
      2: card5_ok = 0;
      3: card3_ok = 0;
      4: seated_a = 0;
      default: seated_b = 0;
    endcase
    wait_gate(1'b0, n);
    chk(n == 3 + FILT_N, req, n, 3 + FILT_N);
    chk(card_rst === 1'b1 && card_pwr_ok === 1'b0 && sig_ok === 1'b0 && drv_en === 1'b0,
        req, card_rst, 1);
    seated_a = 0; seated_b = 0; host5_ok = 0; host3_ok = 0; card5_ok = 0; card3_ok = 0;
    cyc(20);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(2);
    // R10 reset state while held in reset
    chk(gate5_en === 0 && gate3_en === 0 && drv_en === 0 && card_pwr_ok === 0 &&
        sig_ok === 0 && card_rst === 1 && card_rst_n === 0, "R10", card_rst, 1);
    rst_n = 1;
    cyc(2);
    chk(gate5_en === 0 && card_rst === 1 && card_rst_n === 0, "R10", gate5_en, 0);

    // R1: one contact only, then one host rail missing
    seated_a = 1; host5_ok = 1; host3_ok = 1;
    cyc(40);
    chk(gate5_en === 0 && drv_en === 0, "R1", gate5_en, 0);
    seated_b = 1; host3_ok = 0;
    cyc(40);
    chk(gate5_en === 0 && gate3_en === 0, "R1", gate5_en, 0);
    seated_a = 0; seated_b = 0; host5_ok = 0;
    cyc(20);

    // R2: exact insertion delay
    seated_a = 1; seated_b = 1; host5_ok = 1; host3_ok = 1;
    wait_gate(1'b1, n);
    chk(n == 3 + FILT_N + T_HSE, "R2", n, 3 + FILT_N + T_HSE);
    chk(gate3_en === 1 && drv_en === 1, "R2", drv_en, 1);
    chk(card_rst === 1 && card_pwr_ok === 0, "R3", card_rst, 1);

    // R3: exact reset interval after card rails good
    cyc(5);
    card5_ok = 1; card3_ok = 1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (card_pwr_ok !== 1) chk(card_rst === 1, "R3", card_rst, 1);
      chk(card_rst_n === !card_rst, "R8", card_rst_n, !card_rst);
    end while (card_pwr_ok !== 1'b1 && n < 200);
    chk(n == 3 + FILT_N + T_PURST, "R3", n, 3 + FILT_N + T_PURST);
    chk(sig_ok === 1 && card_rst === 0 && card_rst_n === 1, "R3", card_rst, 0);

    // R6 R7 R11: host reset length sweep
    for (int len = 1; len <= T_PURST + 3; len++) begin
      int hi, exp_len;
      bit gates_kept;
      hi = 0; gates_kept = 1;
      exp_len = (len < T_PURST) ? T_PURST : len;
      host_rst_req = 1;
      for (int k = 0; k < len + T_PURST + 8; k++) begin
        @(negedge clk);
        if (k == len - 1) host_rst_req = 0;
        if (card_rst === 1) hi++;
        if (gate5_en !== 1 || drv_en !== 1) gates_kept = 0;
        chk(card_rst_n === !card_rst, "R8", card_rst_n, !card_rst);
      end
      if (len < T_PURST) chk(hi == exp_len, "R6", hi, exp_len);
      else               chk(hi == exp_len, "R7", hi, exp_len);
      chk(gates_kept, "R11", gates_kept, 1);
    end

    // R9: glitch length sweep on a card rail
    for (int len = 1; len <= FILT_N; len++) begin
      bit dropped;
      dropped = 0;
      card3_ok = 0;
      cyc(len);
      card3_ok = 1;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (card_pwr_ok !== 1) dropped = 1;
      end
      chk(dropped == (len >= FILT_N), "R9", dropped, len >= FILT_N);
      if (dropped) bring_up();
    end
    seated_a = 0; seated_b = 0; host5_ok = 0; host3_ok = 0; card5_ok = 0; card3_ok = 0;
    cyc(20);

    // R4: every rail fault; R5: each contact removed
    fault_test(0, "R4");
    fault_test(1, "R4");
    fault_test(2, "R4");
    fault_test(3, "R4");
    fault_test(4, "R5");
    fault_test(5, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule